// File: doc/BRIEF.md
# OTP Security Lock Controller

This block sits between the on-chip clients and a one-time-programmable configuration array of 32-bit rows. When reset is released it fetches the security word from a fixed row of the array and holds it in a security register. Until that fetch has finished, no client request is taken. From then on the register drives the chip-wide protection controls: the choice of boot entry point, the JTAG access enable, the enable for state access by other processors over the system switch, and the global debug enable.

Every later read or program request is checked against a master lock and a set of per-sector locks. A request that passes goes to the array. A request that fails finishes with an error flag and does not touch the array. A program request to the security row also raises bits in the live register, so the new protection takes effect on the next cycle. Register bits can only be set, never cleared, until the next reset.

The array is expected to return read data one cycle after it is enabled. It combines programmed data with its stored contents, since bits can only be set.

Top module: `otp_secctl`

## Requirements
- R1: After reset is released, `req_ready` and `sec_ready` stay low for exactly two cycles and are high from the third cycle on. During that window the block makes exactly one array access, a read of the security row. A request presented during the window is stalled and gets no response until it is accepted.
- R2: While reset is asserted, and until the load finishes, `jtag_en`, `link_en`, `dbg_en` and `boot_rom_bypass` are all low.
- R3: With security bit 0 (secure boot) set, `boot_rom_bypass` is 1 and `boot_vec` is 0, the first OTP row. With it clear, `boot_rom_bypass` is 0 and `boot_vec` equals the parameter `ROM_VEC`.
- R4: With security bit 1 set, `jtag_en` is 0. Once loaded with the bit clear, `jtag_en` is 1.
- R5: With security bit 2 set, `link_en` is 0. Once loaded with the bit clear, `link_en` is 1.
- R6: With security bit 3 set, `dbg_en` is 0. Once loaded with the bit clear, `dbg_en` is 1.
- R7: With security bit 4 (master lock) set, every read and program request is rejected, whatever the sector locks hold.
- R8: Security bits 8 to 11 lock sectors 0 to 3. The sector of a row is the top two bits of its address. A request to a locked sector is rejected, and requests to unlocked sectors are served.
- R9: An accepted request that is allowed enables the array in the accept cycle, with `arr_wr` equal to `req_write`. In the next cycle `rsp_valid` is 1 and `rsp_err` is 0. `rsp_rdata` then carries the array data for a read and is 0 for a program.
- R10: An allowed program to the security row ORs its bits 0 to 4 and 8 to 11 into the security register, and the outputs follow from the next cycle. A program that would clear a bit has no effect until reset.
- R11: A rejected request makes no array access. In the next cycle `rsp_valid` is 1, `rsp_err` is 1 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | ADDR_W | Row address |
| req_wdata | input | DATA_W | Program data |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_err | output | 1 | Request was rejected by a lock |
| rsp_rdata | output | DATA_W | Read data (0 for programs and rejects) |
| arr_en | output | 1 | Array access enable |
| arr_wr | output | 1 | Array program strobe |
| arr_addr | output | ADDR_W | Array row address |
| arr_wdata | output | DATA_W | Array program data |
| arr_rdata | input | DATA_W | Array read data, valid one cycle after `arr_en` |
| sec_ready | output | 1 | Security word loaded |
| boot_rom_bypass | output | 1 | Boot from OTP instead of boot ROM |
| boot_vec | output | BOOT_W | Boot entry address |
| jtag_en | output | 1 | JTAG access to processor state allowed |
| link_en | output | 1 | State access by other processors allowed |
| dbg_en | output | 1 | Global debug pin function allowed |

## Verification
The hardest case to reach from the ports is a request that arrives while the security word is still being fetched. The bench holds `req_valid` high before reset is released. It then checks, cycle by cycle, that nothing is accepted and no response appears until the load is done. The lock decode is covered by reloading the register through reset many times: once for each combination of the five control bits, and once for each of the sixteen sector-lock patterns, with a read and a program to every row each time. Sticky behaviour is reached by programming the security row at run time, first with set bits and then with a word that tries to clear them.

// File: rtl/otp_secctl_pkg.sv
package otp_secctl_pkg;

   // Bit positions inside the stored security word
   localparam int SB_BOOT   = 0;
   localparam int SB_NOJTAG = 1;
   localparam int SB_NOLINK = 2;
   localparam int SB_NODBG  = 3;
   localparam int SB_MLOCK  = 4;
   localparam int SB_SLOCK0 = 8;

   // Number of single control flags held below the sector-lock field
   localparam int N_FLAGS = 5;

   typedef enum logic [1:0] {
      LD_ISSUE   = 2'd0,
      LD_CAPTURE = 2'd1,
      LD_DONE    = 2'd2
   } ld_state_e;

endpackage

// File: rtl/otp_sec_loader.sv
module otp_sec_loader
   import otp_secctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic ld_en,
   output logic ld_capture,
   output logic loaded
);

   ld_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LD_ISSUE:   state_d = LD_CAPTURE;
         LD_CAPTURE: state_d = LD_DONE;
         default:    state_d = LD_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LD_ISSUE;
      else        state_q <= state_d;
   end

   assign ld_en      = (state_q == LD_ISSUE);
   assign ld_capture = (state_q == LD_CAPTURE);
   assign loaded     = (state_q == LD_DONE);

   // R1
   cap_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_capture |-> $past(ld_en));

endmodule

// File: rtl/otp_sec_reg.sv
module otp_sec_reg #(
   parameter int FLD_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_capture,
   input  logic [FLD_W-1:0] ld_fields,
   input  logic             upd_en,
   input  logic [FLD_W-1:0] upd_fields,
   output logic [FLD_W-1:0] fld_q
);

   if (FLD_W < 1) begin : g_bad_w
      $error("otp_sec_reg: FLD_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fld_q <= '0;
      else if (ld_capture) fld_q <= fld_q | ld_fields;
      else if (upd_en)     fld_q <= fld_q | upd_fields;
   end

   // R10
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_q & $past(fld_q)) == $past(fld_q));

endmodule

// File: rtl/otp_access_gate.sv
module otp_access_gate #(
   parameter int ADDR_W  = 11,
   parameter int NSECT   = 4,
   parameter int SEC_ROW = 2047
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loaded,
   input  logic              mlock,
   input  logic [NSECT-1:0]  slock,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              cli_en,
   output logic              upd_en,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic              rd_pend
);

   localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;

   logic [NSECT-1:0] sect_hit;
   logic             blocked;
   logic             fire;

   if (NSECT == 1) begin : g_one_sect
      assign sect_hit = 1'b1;
   end else begin : g_multi_sect
      for (genvar s = 0; s < NSECT; s++) begin : g_hit
         assign sect_hit[s] = (req_addr[ADDR_W-1 -: SECT_W] == SECT_W'(s));
      end
   end

   assign req_ready = loaded;
   assign fire      = req_valid & req_ready;
   assign blocked   = mlock | (|(sect_hit & slock));
   assign cli_en    = fire & ~blocked;
   assign upd_en    = cli_en & req_write & (req_addr == ADDR_W'(SEC_ROW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rd_pend   <= 1'b0;
      end else begin
         rsp_valid <= fire;
         rsp_err   <= fire & blocked;
         rd_pend   <= cli_en & ~req_write;
      end
   end

   // R7
   mlock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mlock && req_valid) |-> !cli_en);

   // R11
   reject_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> ($past(req_valid) && !$past(cli_en)));

endmodule

// File: rtl/otp_secctl.sv
module otp_secctl
   import otp_secctl_pkg::*;
#(
   parameter int              ROWS    = 2048,
   parameter int              DATA_W  = 32,
   parameter int              NSECT   = 4,
   parameter int              SEC_ROW = ROWS - 1,
   parameter int              BOOT_W  = 32,
   parameter logic [BOOT_W-1:0] ROM_VEC = BOOT_W'(32'h0000_4000),
   localparam int             ADDR_W  = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              arr_en,
   output logic              arr_wr,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              sec_ready,
   output logic              boot_rom_bypass,
   output logic [BOOT_W-1:0] boot_vec,
   output logic              jtag_en,
   output logic              link_en,
   output logic              dbg_en
);

   localparam int FLD_W = N_FLAGS + NSECT;

   if ((ROWS & (ROWS - 1)) != 0 || ROWS < 2) begin : g_bad_rows
      $error("otp_secctl: ROWS must be a power of two");
   end
   if ((NSECT & (NSECT - 1)) != 0 || NSECT > ROWS) begin : g_bad_sect
      $error("otp_secctl: NSECT must be a power of two not above ROWS");
   end
   if (SEC_ROW < 0 || SEC_ROW >= ROWS) begin : g_bad_secrow
      $error("otp_secctl: SEC_ROW outside the array");
   end
   if (DATA_W < SB_SLOCK0 + NSECT) begin : g_bad_data
      $error("otp_secctl: DATA_W too narrow for the sector-lock field");
   end

   logic             ld_en, ld_capture, loaded;
   logic             cli_en, upd_en, rd_pend;
   logic [FLD_W-1:0] fld_q, ld_fields, upd_fields;

   otp_sec_loader u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_en),
      .ld_capture (ld_capture),
      .loaded     (loaded)
   );

   assign ld_fields  = {arr_rdata[SB_SLOCK0 +: NSECT], arr_rdata[N_FLAGS-1:0]};
   assign upd_fields = {req_wdata[SB_SLOCK0 +: NSECT], req_wdata[N_FLAGS-1:0]};

   otp_sec_reg #(.FLD_W(FLD_W)) u_secreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_capture (ld_capture),
      .ld_fields  (ld_fields),
      .upd_en     (upd_en),
      .upd_fields (upd_fields),
      .fld_q      (fld_q)
   );

   otp_access_gate #(.ADDR_W(ADDR_W), .NSECT(NSECT), .SEC_ROW(SEC_ROW)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .loaded    (loaded),
      .mlock     (fld_q[SB_MLOCK]),
      .slock     (fld_q[N_FLAGS +: NSECT]),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_ready (req_ready),
      .cli_en    (cli_en),
      .upd_en    (upd_en),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rd_pend   (rd_pend)
   );

   // Array port: the loader owns it until loaded, clients afterwards
   assign arr_en    = ld_en | cli_en;
   assign arr_wr    = cli_en & req_write;
   assign arr_addr  = ld_en ? ADDR_W'(SEC_ROW) : req_addr;
   assign arr_wdata = req_wdata;
   assign rsp_rdata = rd_pend ? arr_rdata : '0;

   // Protection controls
   assign sec_ready       = loaded;
   assign boot_rom_bypass = loaded & fld_q[SB_BOOT];
   assign boot_vec        = boot_rom_bypass ? '0 : ROM_VEC;
   assign jtag_en         = loaded & ~fld_q[SB_NOJTAG];
   assign link_en         = loaded & ~fld_q[SB_NOLINK];
   assign dbg_en          = loaded & ~fld_q[SB_NODBG];

   // R1
   stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sec_ready) |=> !rsp_valid);

   // R1
   load_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> !cli_en);

   // R4
   jtag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fld_q[SB_NOJTAG]) |-> !jtag_en);

   // R9
   rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));

endmodule

// File: tb/sim_otp_secctl.sv
`timescale 1ns/1ps
module sim_otp_secctl;

   localparam int ROWS    = 64;
   localparam int DATA_W  = 32;
   localparam int NSECT   = 4;
   localparam int SEC_ROW = ROWS - 1;
   localparam int BOOT_W  = 32;
   localparam logic [31:0] ROM_V = 32'h0000_4000;
   localparam int ADDR_W  = $clog2(ROWS);
   localparam int SPS     = ROWS / NSECT;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_ready, rsp_valid, rsp_err;
   logic [DATA_W-1:0] rsp_rdata;
   logic              arr_en, arr_wr;
   logic [ADDR_W-1:0] arr_addr;
   logic [DATA_W-1:0] arr_wdata;
   logic [DATA_W-1:0] arr_rdata = '0;
   logic              sec_ready, boot_rom_bypass, jtag_en, link_en, dbg_en;
   logic [BOOT_W-1:0] boot_vec;

   int unsigned n_tests = 0, n_fail = 0, acc_cnt = 0;

   always #2.5 clk = ~clk;

   otp_secctl #(.ROWS(ROWS), .DATA_W(DATA_W), .NSECT(NSECT), .SEC_ROW(SEC_ROW),
                .BOOT_W(BOOT_W), .ROM_VEC(ROM_V)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .arr_en(arr_en), .arr_wr(arr_wr), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
      .sec_ready(sec_ready), .boot_rom_bypass(boot_rom_bypass), .boot_vec(boot_vec),
      .jtag_en(jtag_en), .link_en(link_en), .dbg_en(dbg_en)
   );

   // Array model: one-cycle read latency, programming only sets bits
   logic [DATA_W-1:0] mem [ROWS];
   logic              pl_go = 1'b0, pl_clr = 1'b0;
   logic [DATA_W-1:0] pl_val = '0;

   always @(posedge clk) begin
      if (pl_clr) begin
         for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      end else if (pl_go) begin
         mem[SEC_ROW] <= pl_val;
      end else if (arr_en && arr_wr) begin
         mem[arr_addr] <= mem[arr_addr] | arr_wdata;
      end
      if (arr_en) arr_rdata <= mem[arr_addr];
      if (rst_n && arr_en) acc_cnt <= acc_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int a);
      return {a[7:0], ~a[7:0], a[7:0] ^ 8'h5A, 8'hC3};
   endfunction

   // Enters and leaves at a falling edge
   task automatic do_reset(input logic [31:0] word, input logic clear);
      int unsigned c0;
      rst_n = 1'b0; req_valid = 1'b0;
      pl_val = word; pl_go = 1'b1; pl_clr = clear;
      @(negedge clk);
      pl_go = 1'b0; pl_clr = 1'b0;
      if (clear) begin
         pl_go = 1'b1;
         @(negedge clk);
         pl_go = 1'b0;
      end
      // R2: protective state while in reset
      chk("R2 reset", {28'd0, jtag_en, link_en, dbg_en, boot_rom_bypass}, 32'd0);
      chk("R1 reset ready", {31'd0, req_ready}, 32'd0);
      rst_n = 1'b1;
      c0 = acc_cnt;
      @(negedge clk);
      chk("R1 ready low", {30'd0, req_ready, sec_ready}, 32'd0);
      chk("R2 load", {28'd0, jtag_en, link_en, dbg_en, boot_rom_bypass}, 32'd0);
      @(negedge clk);
      chk("R1 ready high", {30'd0, req_ready, sec_ready}, 32'd3);
      chk("R1 one load access", acc_cnt - c0, 32'd1);
   endtask

   // Enters and leaves at a falling edge
   task automatic xact(input logic wr, input int a, input logic [31:0] wd,
                       output logic err, output logic [31:0] rd, output int unsigned touched);
      int unsigned c0;
      req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = wd;
      while (!req_ready) @(negedge clk);
      c0 = acc_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      err = rsp_err; rd = rsp_rdata; touched = acc_cnt - c0;
   endtask

   logic        e;
   logic [31:0] r;
   int unsigned t;
   bit          done = 1'b0;

   initial begin
      // R1: request held during the load is stalled
      do_reset(32'd0, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(5);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 stall cyc1", {30'd0, req_ready, rsp_valid}, 32'd0);
      @(negedge clk);
      chk("R1 stall cyc2", {30'd0, req_ready, rsp_valid}, 32'd2);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 stalled rsp", {30'd0, rsp_valid, rsp_err}, 32'd2);
      @(negedge clk);

      // R9: program and read back every ordinary row, no locks
      do_reset(32'd0, 1'b0);
      chk("R4 open", {31'd0, jtag_en}, 32'd1);
      chk("R5 open", {31'd0, link_en}, 32'd1);
      chk("R6 open", {31'd0, dbg_en}, 32'd1);
      for (int a = 0; a < ROWS - 1; a++) begin
         xact(1'b1, a, pat(a), e, r, t);
         chk("R9 wr ok", {30'd0, e, t[0]}, 32'd1);
         chk("R9 wr rdata", r, 32'd0);
         xact(1'b0, a, '0, e, r, t);
         chk("R9 rd ok", {31'd0, e}, 32'd0);
         chk("R9 rd data", r, pat(a));
      end
      for (int a = 0; a < ROWS - 1; a++) begin
         xact(1'b0, a, '0, e, r, t);
         chk("R9 reread", r, pat(a));
      end

      // R10: run-time programming of the security row is sticky
      xact(1'b1, SEC_ROW, 32'h0000_0002, e, r, t);
      chk("R10 set jtag off", {30'd0, jtag_en, link_en}, 32'd1);
      xact(1'b1, SEC_ROW, 32'h0000_0000, e, r, t);
      chk("R10 clear ignored", {31'd0, jtag_en}, 32'd0);
      xact(1'b1, SEC_ROW, 32'h0000_0010, e, r, t);
      chk("R10 mlock live", {31'd0, jtag_en}, 32'd0);
      xact(1'b0, 0, '0, e, r, t);
      chk("R7 after live mlock", {31'd0, e}, 32'd1);
      chk("R11 no touch", t, 32'd0);
      chk("R11 rdata zero", r, 32'd0);

      // R3-R7: every combination of the five control bits
      for (int v = 0; v < 32; v++) begin
         do_reset(32'(v), 1'b0);
         chk("R3 bypass", {31'd0, boot_rom_bypass}, 32'(v & 1));
         chk("R3 boot_vec", boot_vec, ((v & 1) != 0) ? 32'd0 : ROM_V);
         chk("R4 jtag", {31'd0, jtag_en}, ((v >> 1) & 1) != 0 ? 32'd0 : 32'd1);
         chk("R5 link", {31'd0, link_en}, ((v >> 2) & 1) != 0 ? 32'd0 : 32'd1);
         chk("R6 dbg",  {31'd0, dbg_en},  ((v >> 3) & 1) != 0 ? 32'd0 : 32'd1);
         xact(1'b0, 0, '0, e, r, t);
         chk("R7 mlock read", {31'd0, e}, 32'((v >> 4) & 1));
         chk("R11 access count", t, ((v >> 4) & 1) != 0 ? 32'd0 : 32'd1);
      end

      // R8: every sector-lock pattern against every row, reads and programs
      for (int cfg = 0; cfg < 16; cfg++) begin
         do_reset(32'(cfg) << 8, 1'b0);
         for (int a = 0; a < ROWS; a++) begin
            logic lk;
            lk = ((cfg >> (a / SPS)) & 1) != 0;
            xact(1'b0, a, '0, e, r, t);
            chk("R8 rd err", {31'd0, e}, {31'd0, lk});
            chk("R11 rd touch", t, lk ? 32'd0 : 32'd1);
            chk("R9 R11 rd data", r, lk ? 32'd0 : ((a == SEC_ROW) ? (32'(cfg) << 8) : pat(a)));
            xact(1'b1, a, '0, e, r, t);
            chk("R8 wr err", {31'd0, e}, {31'd0, lk});
            chk("R11 wr touch", t, lk ? 32'd0 : 32'd1);
         end
      end

      // R7: master lock overrides an all-open sector field
      do_reset(32'h0000_0010, 1'b0);
      for (int s = 0; s < NSECT; s++) begin
         xact(1'b1, s * SPS, 32'hFFFF_FFFF, e, r, t);
         chk("R7 mlock wr", {31'd0, e}, 32'd1);
         chk("R7 mlock no touch", t, 32'd0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #750000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule